// File: doc/BRIEF.md
# Speculative Input-Port Local Arbiter

This block sits at one input port of a packet router and proposes, once per clock, one buffered packet for dispatch toward an output port. It looks at a head-of-queue slot for every pairing of packet class and virtual channel. The port has seven classes. The special class uses only its first channel. Every other class has three channels: adaptive, deadlock-free channel 0 and deadlock-free channel 1. Each slot is a candidate only if it passes every readiness test. These tests cover the slot's own state, the downstream credit for its channel, and whether a permitted output and the crossbar path to it are free. They also cover a starvation veto and the rule that keeps I/O reads in order behind I/O writes.

Among the ready slots, a least-recently-selected age matrix first picks a class. A second age matrix, private to that class, then picks the channel within it. The nomination is registered. It carries the class, the channel and a one-hot output chosen as the lowest-numbered free output that the slot permits. The output arbiters answer exactly two cycles after the nomination appears. A loss returns the slot to the candidate pool. A grant holds the slot back until the entry table withdraws its valid bit. The nomination bus has no ready signal. Back-pressure reaches the block only through the response pins and the busy, credit and veto inputs.

Classes are coded 0 read I/O, 1 write I/O, 2 request, 3 forward, 4 special, 5 non-block response, 6 block response. Channels are coded 0 adaptive, 1 channel 0, 2 channel 1. Slot index = class*3 + channel. Per-slot fields are packed at that index in the flat vectors.

Top module: `spec_local_arb`

## Requirements
- R1: During and right after reset, `nom_valid` is low. Both levels of age matrices start with the lower index counted as older.
- R2: A slot is a candidate only when its valid bit is high, its dispatched bit is low and its credit count is nonzero.
- R3: A slot needs a permitted output (route bit set) whose `out_busy` and `path_busy` bits are both low. The nomination names exactly one output: the lowest-numbered one meeting that test.
- R4: A slot whose `slot_starve` bit is high is never nominated.
- R5: A read I/O slot (class 0, channel c) with `rd_after_wr[c]` high is not a candidate while any write I/O slot (class 1) is valid and not dispatched. Write I/O slots are never held back by reads.
- R6: Among classes with a candidate, the class selected least recently wins.
- R7: Within the winning class, the channel selected least recently among its candidates wins.
- R8: A nominated slot is not nominated again until its response arrives, two cycles after the nomination cycle. After a loss it is a candidate again from the cycle after the response.
- R9: After a grant, the slot is not nominated again until its valid bit has been seen low at a clock edge.
- R10: Channels 1 and 2 of the special class (slots 13 and 14) are ignored whatever their inputs.
- R11: The nomination is registered. It reflects the inputs of the previous cycle and never changes between clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 21 | Slot holds a packet |
| slot_dispatched | input | 21 | Slot packet already sent |
| slot_route | input | 21*NUM_OUT | Permitted outputs per slot |
| slot_credit | input | 21*CRED_W | Downstream free buffers for the slot's channel |
| slot_starve | input | 21 | Starvation veto per slot |
| rd_after_wr | input | 3 | Read I/O slot c is younger than outstanding writes |
| out_busy | input | NUM_OUT | Output port busy |
| path_busy | input | NUM_OUT | Crossbar path to output busy |
| resp_valid | input | 1 | Output arbiter response present |
| resp_grant | input | 1 | Response is a grant (else loss) |
| nom_valid | output | 1 | Nomination present |
| nom_class | output | 3 | Nominated class |
| nom_chan | output | 2 | Nominated channel |
| nom_out | output | NUM_OUT | One-hot nominated output |

## Verification
The bench builds the block with seven outputs and a four-bit credit field. With seven outputs, the lowest-free-output choice can be exercised with busy and path-busy bits falling both below and above a permitted route. With a four-bit credit field, both zero credit and the full count of 15 are reachable. The full seven-class, three-channel slot set is present, so the ignored special channels, the read/write ordering pair and separate per-class age matrices all take part. Responses are returned at the fixed two-cycle offset, which exposes the pending, retry and grant-hold windows cycle by cycle.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int NCLS        = 7;
  localparam int NCH         = 3;
  localparam int NSLOT       = NCLS * NCH;
  localparam int CLS_W       = 3;
  localparam int CH_W        = 2;
  localparam int IDX_W       = $clog2(NSLOT);
  localparam int CLS_RDIO    = 0;
  localparam int CLS_WRIO    = 1;
  localparam int CLS_SPECIAL = 4;

  function automatic bit slot_live(input int s);
    return !((s / NCH) == CLS_SPECIAL && (s % NCH) != 0);
  endfunction
endpackage

// File: rtl/lsa_lrs.sv
module lsa_lrs #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         upd,
  output logic [N-1:0] gnt
);
  // older[i][j] set: entry i was selected less recently than entry j
  logic [N-1:0] older [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      gnt[i] = req[i];
      for (int j = 0; j < N; j++)
        if (j != i && req[j] && !older[i][j]) gnt[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          older[i][j] <= (i < j);
    end else if (upd) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (gnt[i])      older[i][j] <= 1'b0;
          else if (gnt[j]) older[i][j] <= 1'b1;
    end
  end

  // R6
  lrs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R7
  lrs_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));
endmodule

// File: rtl/lsa_slot_filter.sv
module lsa_slot_filter #(
  parameter int NUM_OUT = 7,
  parameter int CRED_W  = 4
) (
  input  logic               valid,
  input  logic               dispatched,
  input  logic               pending,
  input  logic               held,
  input  logic               starve,
  input  logic               order_block,
  input  logic [CRED_W-1:0]  credit,
  input  logic [NUM_OUT-1:0] route,
  input  logic [NUM_OUT-1:0] out_busy,
  input  logic [NUM_OUT-1:0] path_busy,
  output logic               ready,
  output logic [NUM_OUT-1:0] pick
);
  logic [NUM_OUT-1:0] free_out;

  always_comb begin
    free_out = route & ~out_busy & ~path_busy;
    pick     = free_out & (~free_out + NUM_OUT'(1));
    ready    = valid && !dispatched && !pending && !held && !starve &&
               !order_block && (|credit) && (|free_out);
  end
endmodule

// File: rtl/spec_local_arb.sv
module spec_local_arb
  import lsa_pkg::*;
#(
  parameter int NUM_OUT = 7,
  parameter int CRED_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSLOT-1:0]          slot_valid,
  input  logic [NSLOT-1:0]          slot_dispatched,
  input  logic [NSLOT*NUM_OUT-1:0]  slot_route,
  input  logic [NSLOT*CRED_W-1:0]   slot_credit,
  input  logic [NSLOT-1:0]          slot_starve,
  input  logic [NCH-1:0]            rd_after_wr,
  input  logic [NUM_OUT-1:0]        out_busy,
  input  logic [NUM_OUT-1:0]        path_busy,
  input  logic                      resp_valid,
  input  logic                      resp_grant,
  output logic                      nom_valid,
  output logic [CLS_W-1:0]          nom_class,
  output logic [CH_W-1:0]           nom_chan,
  output logic [NUM_OUT-1:0]        nom_out
);
  logic [NSLOT-1:0]   pend_q, held_q, ready, sel_vec;
  logic [NUM_OUT-1:0] pick [NSLOT];
  logic [NCLS-1:0]    cls_req, cls_gnt;
  logic [NCH-1:0]     ch_gnt [NCLS];
  logic               wr_open, any_sel;
  logic [IDX_W-1:0]   sel_idx, nom_idx, s2_idx, s3_idx;
  logic [CLS_W-1:0]   sel_cls;
  logic [CH_W-1:0]    sel_ch;
  logic [NUM_OUT-1:0] sel_out;
  logic               s2_v, s3_v;

  // any outstanding write I/O packet fences younger reads
  always_comb begin
    wr_open = 1'b0;
    for (int c = 0; c < NCH; c++)
      wr_open |= slot_valid[CLS_WRIO*NCH + c] & ~slot_dispatched[CLS_WRIO*NCH + c];
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic live_valid, ord_blk;
    assign live_valid = slot_live(s) ? slot_valid[s] : 1'b0;
    if ((s / NCH) == CLS_RDIO) begin : g_rd
      assign ord_blk = rd_after_wr[s % NCH] & wr_open;
    end else begin : g_other
      assign ord_blk = 1'b0;
    end
    lsa_slot_filter #(.NUM_OUT(NUM_OUT), .CRED_W(CRED_W)) u_filt (
      .valid       (live_valid),
      .dispatched  (slot_dispatched[s]),
      .pending     (pend_q[s]),
      .held        (held_q[s]),
      .starve      (slot_starve[s]),
      .order_block (ord_blk),
      .credit      (slot_credit[s*CRED_W +: CRED_W]),
      .route       (slot_route[s*NUM_OUT +: NUM_OUT]),
      .out_busy    (out_busy),
      .path_busy   (path_busy),
      .ready       (ready[s]),
      .pick        (pick[s])
    );
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    assign cls_req[c] = |ready[c*NCH +: NCH];
    lsa_lrs #(.N(NCH)) u_ch_lrs (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (ready[c*NCH +: NCH]),
      .upd   (cls_gnt[c]),
      .gnt   (ch_gnt[c])
    );
    assign sel_vec[c*NCH +: NCH] = cls_gnt[c] ? ch_gnt[c] : '0;
  end

  assign any_sel = |cls_req;

  lsa_lrs #(.N(NCLS)) u_cls_lrs (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (cls_req),
    .upd   (any_sel),
    .gnt   (cls_gnt)
  );

  always_comb begin
    sel_idx = '0;
    sel_cls = '0;
    sel_ch  = '0;
    sel_out = '0;
    for (int s = 0; s < NSLOT; s++)
      if (sel_vec[s]) begin
        sel_idx = IDX_W'(s);
        sel_cls = CLS_W'(s / NCH);
        sel_ch  = CH_W'(s % NCH);
        sel_out = pick[s];
      end
  end

  // nomination register and the two-cycle response tracking pipe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nom_valid <= 1'b0;
      nom_class <= '0;
      nom_chan  <= '0;
      nom_out   <= '0;
      nom_idx   <= '0;
      s2_v      <= 1'b0;
      s2_idx    <= '0;
      s3_v      <= 1'b0;
      s3_idx    <= '0;
    end else begin
      nom_valid <= any_sel;
      nom_class <= sel_cls;
      nom_chan  <= sel_ch;
      nom_out   <= any_sel ? sel_out : '0;
      nom_idx   <= sel_idx;
      s2_v      <= nom_valid;
      s2_idx    <= nom_idx;
      s3_v      <= s2_v;
      s3_idx    <= s2_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      held_q <= '0;
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (any_sel && sel_vec[s])
          pend_q[s] <= 1'b1;
        else if (resp_valid && s3_v && s3_idx == IDX_W'(s))
          pend_q[s] <= 1'b0;
        if (resp_valid && s3_v && resp_grant && s3_idx == IDX_W'(s))
          held_q[s] <= 1'b1;
        else if (!slot_valid[s])
          held_q[s] <= 1'b0;
      end
    end
  end

  // R3
  nom_one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nom_valid |-> $countones(nom_out) == 1);
  // R3
  nom_out_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nom_valid |-> (nom_out & $past(out_busy | path_busy)) == '0);
  // R4
  starve_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nom_valid |-> (($past(slot_starve) >> nom_idx) & NSLOT'(1)) == '0);
  // R2
  nom_had_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nom_valid |-> (($past(slot_valid) >> nom_idx) & NSLOT'(1)) != '0);
  // R8
  no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nom_valid && s2_v) |-> nom_idx != s2_idx);
  // R8
  no_repeat_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nom_valid && s3_v) |-> nom_idx != s3_idx);
  // R8
  resp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> s3_v);
endmodule

// File: tb/sim_spec_local_arb.sv
module sim_spec_local_arb;
  localparam int NO = 7;
  localparam int CW = 4;
  localparam int NS = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0]    slot_valid = '0, slot_dispatched = '0, slot_starve = '0;
  logic [NS*NO-1:0] slot_route = '0;
  logic [NS*CW-1:0] slot_credit = '0;
  logic [2:0]       rd_after_wr = '0;
  logic [NO-1:0]    out_busy = '0, path_busy = '0;
  logic             resp_valid = 1'b0, resp_grant = 1'b0;
  logic             nom_valid;
  logic [2:0]       nom_class;
  logic [1:0]       nom_chan;
  logic [NO-1:0]    nom_out;

  int  n_chk = 0, n_bad = 0;
  logic [1:0] hist = '0;
  logic grant_mode = 1'b0;

  always #10 clk = ~clk;

  spec_local_arb #(.NUM_OUT(NO), .CRED_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid),
    .slot_dispatched(slot_dispatched), .slot_route(slot_route),
    .slot_credit(slot_credit), .slot_starve(slot_starve),
    .rd_after_wr(rd_after_wr), .out_busy(out_busy), .path_busy(path_busy),
    .resp_valid(resp_valid), .resp_grant(resp_grant), .nom_valid(nom_valid),
    .nom_class(nom_class), .nom_chan(nom_chan), .nom_out(nom_out));

  typedef struct packed {
    logic [3:0]    req;
    logic [2:0]    cls;
    logic [1:0]    ch;
    logic [NO-1:0] route, obusy, pbusy;
    logic [CW-1:0] cred;
    logic          starve, disp, ev;
    logic [NO-1:0] eout;
  } vec_t;

  localparam vec_t TBL [11] = '{
    '{4'd2,  3'd2, 2'd0, 7'b0000011, 7'b0000000, 7'b0000000, 4'd3,  1'b0, 1'b0, 1'b1, 7'b0000001}, // R2 R3
    '{4'd3,  3'd2, 2'd0, 7'b0000011, 7'b0000001, 7'b0000000, 4'd3,  1'b0, 1'b0, 1'b1, 7'b0000010}, // R3
    '{4'd3,  3'd2, 2'd0, 7'b0000011, 7'b0000001, 7'b0000010, 4'd3,  1'b0, 1'b0, 1'b0, 7'b0000000}, // R3
    '{4'd2,  3'd3, 2'd1, 7'b0000100, 7'b0000000, 7'b0000000, 4'd0,  1'b0, 1'b0, 1'b0, 7'b0000000}, // R2 credit
    '{4'd4,  3'd5, 2'd2, 7'b0001000, 7'b0000000, 7'b0000000, 4'd1,  1'b1, 1'b0, 1'b0, 7'b0000000}, // R4
    '{4'd2,  3'd6, 2'd0, 7'b0010000, 7'b0000000, 7'b0000000, 4'd2,  1'b0, 1'b1, 1'b0, 7'b0000000}, // R2 dispatched
    '{4'd2,  3'd6, 2'd2, 7'b1000000, 7'b0000000, 7'b0000000, 4'd15, 1'b0, 1'b0, 1'b1, 7'b1000000}, // R2
    '{4'd10, 3'd4, 2'd1, 7'b0000001, 7'b0000000, 7'b0000000, 4'd5,  1'b0, 1'b0, 1'b0, 7'b0000000}, // R10
    '{4'd10, 3'd4, 2'd0, 7'b0000001, 7'b0000000, 7'b0000000, 4'd5,  1'b0, 1'b0, 1'b1, 7'b0000001}, // R10
    '{4'd3,  3'd0, 2'd1, 7'b0100100, 7'b0000100, 7'b0000000, 4'd1,  1'b0, 1'b0, 1'b1, 7'b0100000}, // R3
    '{4'd3,  3'd1, 2'd2, 7'b0110000, 7'b0000000, 7'b0000000, 4'd1,  1'b0, 1'b0, 1'b1, 7'b0010000}  // R3
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic step();
    @(negedge clk);
    resp_valid = hist[1];
    resp_grant = grant_mode;
    hist[1] = hist[0];
    hist[0] = nom_valid;
  endtask

  task automatic clear_all();
    slot_valid = '0; slot_dispatched = '0; slot_starve = '0;
    slot_route = '0; slot_credit = '0; rd_after_wr = '0;
    out_busy = '0; path_busy = '0;
  endtask

  task automatic put(input int c, input int ch, input logic [NO-1:0] rt, input int cr);
    int idx;
    idx = c * 3 + ch;
    slot_valid[idx] = 1'b1;
    slot_route[idx*NO +: NO] = rt;
    slot_credit[idx*CW +: CW] = CW'(cr);
  endtask

  task automatic drain();
    slot_valid = '0;
    repeat (4) step();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    hist = '0;
    resp_valid = 1'b0;
    clear_all();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic expect_nom(input string tag, input int c, input int ch);
    chk(nom_valid == 1'b1, tag, int'(nom_valid), 1);
    if (nom_valid) begin
      chk(nom_class == 3'(c), tag, int'(nom_class), c);
      chk(nom_chan == 2'(ch), tag, int'(nom_chan), ch);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    step();
    chk(nom_valid == 1'b0, "R1 reset", int'(nom_valid), 0);

    // R11: nothing appears between edges
    put(2, 1, 7'b0000001, 1);
    #1;
    chk(nom_valid == 1'b0, "R11 registered", int'(nom_valid), 0);
    step();
    expect_nom("R11 next edge", 2, 1);
    drain();

    for (int r = 0; r < 11; r++) begin
      clear_all();
      put(int'(TBL[r].cls), int'(TBL[r].ch), TBL[r].route, int'(TBL[r].cred));
      out_busy = TBL[r].obusy;
      path_busy = TBL[r].pbusy;
      slot_starve[TBL[r].cls*3 + TBL[r].ch] = TBL[r].starve;
      slot_dispatched[TBL[r].cls*3 + TBL[r].ch] = TBL[r].disp;
      step();
      chk(nom_valid == TBL[r].ev, $sformatf("R%0d row %0d valid", TBL[r].req, r),
          int'(nom_valid), int'(TBL[r].ev));
      if (TBL[r].ev) begin
        chk(nom_class == TBL[r].cls && nom_chan == TBL[r].ch,
            $sformatf("R%0d row %0d slot", TBL[r].req, r),
            int'(nom_class) * 3 + int'(nom_chan), int'(TBL[r].cls) * 3 + int'(TBL[r].ch));
        chk(nom_out == TBL[r].eout, $sformatf("R%0d row %0d out", TBL[r].req, r),
            int'(nom_out), int'(TBL[r].eout));
      end
      drain();
    end

    // R6: class order follows recency
    do_reset();
    put(2, 0, 7'b0000001, 1);
    step();
    expect_nom("R6 first", 2, 0);
    drain();
    put(2, 0, 7'b0000001, 1);
    put(5, 0, 7'b0000001, 1);
    step();
    expect_nom("R6 less recent class", 5, 0);
    drain();
    put(2, 0, 7'b0000001, 1);
    put(5, 0, 7'b0000001, 1);
    step();
    expect_nom("R6 swap back", 2, 0);
    drain();

    // R7: channel order within a class
    put(3, 0, 7'b0000001, 1);
    step();
    expect_nom("R7 first", 3, 0);
    drain();
    put(3, 0, 7'b0000001, 1);
    put(3, 2, 7'b0000001, 1);
    step();
    expect_nom("R7 less recent chan", 3, 2);
    drain();
    put(3, 0, 7'b0000001, 1);
    put(3, 2, 7'b0000001, 1);
    step();
    expect_nom("R7 swap back", 3, 0);
    drain();

    // R5: younger read may not pass outstanding write
    do_reset();
    put(0, 0, 7'b0000001, 1);
    put(1, 0, 7'b0000001, 1);
    rd_after_wr = 3'b001;
    step();
    expect_nom("R5 write first", 1, 0);
    drain();
    put(0, 0, 7'b0000001, 1);
    put(1, 0, 7'b0000001, 1);
    slot_starve[3] = 1'b1;
    rd_after_wr = 3'b001;
    step();
    chk(nom_valid == 1'b0, "R5 read fenced", int'(nom_valid), 0);
    drain();
    clear_all();
    put(0, 0, 7'b0000001, 1);
    put(1, 0, 7'b0000001, 1);
    slot_dispatched[3] = 1'b1;
    rd_after_wr = 3'b001;
    step();
    expect_nom("R5 fence lifted", 0, 0);
    drain();
    clear_all();

    // R8: pending window then retry after loss
    grant_mode = 1'b0;
    put(2, 1, 7'b0000010, 2);
    step();
    expect_nom("R8 nominate", 2, 1);
    for (int k = 0; k < 3; k++) begin
      step();
      chk(nom_valid == 1'b0, "R8 pending", int'(nom_valid), 0);
    end
    step();
    expect_nom("R8 retry", 2, 1);
    drain();

    // R9: granted slot held until valid drops
    grant_mode = 1'b1;
    put(5, 1, 7'b0000100, 2);
    step();
    expect_nom("R9 nominate", 5, 1);
    for (int k = 0; k < 5; k++) begin
      step();
      chk(nom_valid == 1'b0, "R9 held", int'(nom_valid), 0);
    end
    slot_valid[16] = 1'b0;
    step();
    slot_valid[16] = 1'b1;
    step();
    expect_nom("R9 released", 5, 1);
    drain();
    grant_mode = 1'b0;
    repeat (4) step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule